// File: doc/BRIEF.md
# Link-Up Stability Qualifier

This block turns a raw, possibly bouncing link-status input into a qualified link-up level. The raw status must stay high for a selectable period before the qualified output rises. Any low sample clears the output on the next clock and restarts the timing. A 3-bit code picks the period from a fixed table that runs from instantaneous to two seconds. Time is measured in pulses of a one-cycle microsecond tick. Code 2 (1 ms) is the usual setting.

The block also has a startup check, separate from the qualifier. A start pulse launches it. The check then samples the raw status once every `POLL_TICKS` microsecond ticks. It reports success once it has seen the required number of consecutive good samples. It reports failure once the number of bad samples reaches the retry limit. Both limits are 7-bit values in the range 0 to 127. The two result flags are levels and hold until the next start pulse.

Top module: `link_stab_qual`

## Requirements
- R1: After reset, `link_up`, `startup_done` and `startup_fail` are all low.
- R2: The period code selects the number of ticks the raw status must stay high: 0→0, 1→500, 2→1000, 3→64000, 4→256000, 5→512000, 6→1000000, 7→2000000. For codes 1 to 7, `link_up` rises at the clock edge that carries the N-th tick seen while the raw status is high.
- R3: A low raw status clears `link_up` at the next clock edge and restarts the tick count from zero.
- R4: With code 0, `link_up` equals the raw status delayed by one clock.
- R5: The stability count advances only on clocks where `tick_us` is high. Without ticks, a nonzero code never raises `link_up`.
- R6: While the check runs, it samples `link_raw` on every `POLL_TICKS`-th tick. The first sample comes `POLL_TICKS` ticks after the start pulse. Each high sample adds one to the valid count. When the valid count reaches `valid_limit`, `startup_done` rises.
- R7: A low sample adds one to the retry count and clears the valid count, so the good samples must be consecutive. When the retry count reaches `retry_limit`, `startup_fail` rises.
- R8: If `valid_limit` is 0, `startup_done` rises at the clock edge that takes the start pulse. Otherwise, if `retry_limit` is 0, `startup_fail` rises at that edge.
- R9: `startup_done` and `startup_fail` hold their value until the next start pulse. A start pulse clears both and restarts all counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle microsecond time-base pulse |
| link_raw | input | 1 | Unqualified link status |
| period_code | input | 3 | Stability period select |
| start_go | input | 1 | One-cycle pulse that launches the startup check |
| valid_limit | input | 7 | Consecutive good samples needed for success |
| retry_limit | input | 7 | Bad samples that end the check with failure |
| link_up | output | 1 | Qualified link-up level |
| startup_done | output | 1 | Startup check succeeded |
| startup_fail | output | 1 | Startup check failed |

## Verification
The bench measures the rise of `link_up` to the exact edge for codes 0 to 3. A one-off error in the period compare would move that edge by one cycle. It drops the raw status partway through a period. A timer that paused instead of restarting would then qualify about 600 cycles early. It also runs the startup check with a bad sample between good ones, which shows whether the valid count is cleared or only held. The zero-limit starts and the hold of the result flags across later link activity catch a check that needs at least one poll, or one that keeps polling after it has ended.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
   localparam int unsigned MAX_PERIOD_US = 2000000;
   localparam int unsigned PER_CNT_W     = $clog2(MAX_PERIOD_US + 1);
   localparam int unsigned CODE_W        = 3;
   localparam int unsigned LIM_W         = 7;

   typedef enum logic [1:0] {
      CHK_IDLE = 2'd0,
      CHK_RUN  = 2'd1,
      CHK_DONE = 2'd2,
      CHK_FAIL = 2'd3
   } chk_state_t;

   // Stability period, in microsecond ticks, for each code
   function automatic logic [PER_CNT_W-1:0] period_ticks(input logic [CODE_W-1:0] code);
      logic [PER_CNT_W-1:0] t;
      case (code)
         3'd0:    t = PER_CNT_W'(0);
         3'd1:    t = PER_CNT_W'(500);
         3'd2:    t = PER_CNT_W'(1000);
         3'd3:    t = PER_CNT_W'(64000);
         3'd4:    t = PER_CNT_W'(256000);
         3'd5:    t = PER_CNT_W'(512000);
         3'd6:    t = PER_CNT_W'(1000000);
         default: t = PER_CNT_W'(2000000);
      endcase
      return t;
   endfunction
endpackage

// File: rtl/lsq_stab_timer.sv
module lsq_stab_timer
   import lsq_pkg::*;
#(
   parameter int unsigned CNT_W = PER_CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              raw,
   input  logic [CODE_W-1:0] code,
   output logic              up
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   cnt_nxt;
   logic [CNT_W:0]   lim;

   assign cnt_nxt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
   assign lim     = {1'b0, CNT_W'(period_ticks(code))};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         up  <= 1'b0;
      end else if (!raw) begin
         cnt <= '0;
         up  <= 1'b0;
      end else if (code == '0) begin
         cnt <= '0;
         up  <= 1'b1;
      end else if (!up && tick) begin
         if (cnt_nxt >= lim) begin
            cnt <= '0;
            up  <= 1'b1;
         end else begin
            cnt <= cnt_nxt[CNT_W-1:0];
         end
      end
   end
endmodule

// File: rtl/lsq_startup_chk.sv
module lsq_startup_chk
   import lsq_pkg::*;
#(
   parameter int unsigned POLL_TICKS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             raw,
   input  logic             start,
   input  logic [LIM_W-1:0] vlim,
   input  logic [LIM_W-1:0] rlim,
   output logic             done,
   output logic             fail
);
   localparam int unsigned PCW = (POLL_TICKS > 1) ? $clog2(POLL_TICKS) : 1;

   chk_state_t       st;
   logic [LIM_W-1:0] vcnt;
   logic [LIM_W-1:0] rcnt;
   logic [LIM_W:0]   vnxt;
   logic [LIM_W:0]   rnxt;
   logic             poll;
   logic             running;

   assign running = (st == CHK_RUN);

   generate
      if (POLL_TICKS == 1) begin : g_poll_each
         assign poll = running && tick;
      end else begin : g_poll_div
         logic [PCW-1:0] pcnt;
         always_ff @(posedge clk) begin
            if (!rst_n || start) begin
               pcnt <= '0;
            end else if (running && tick) begin
               if (pcnt == PCW'(POLL_TICKS - 1)) pcnt <= '0;
               else                              pcnt <= pcnt + 1'b1;
            end
         end
         assign poll = running && tick && (pcnt == PCW'(POLL_TICKS - 1));
      end
   endgenerate

   assign vnxt = {1'b0, vcnt} + 1'b1;
   assign rnxt = {1'b0, rcnt} + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= CHK_IDLE;
         vcnt <= '0;
         rcnt <= '0;
      end else if (start) begin
         vcnt <= '0;
         rcnt <= '0;
         if (vlim == '0)      st <= CHK_DONE;
         else if (rlim == '0) st <= CHK_FAIL;
         else                 st <= CHK_RUN;
      end else if (poll) begin
         if (raw) begin
            if (vnxt >= {1'b0, vlim}) st <= CHK_DONE;
            else                      vcnt <= vnxt[LIM_W-1:0];
         end else begin
            vcnt <= '0;
            if (rnxt >= {1'b0, rlim}) st <= CHK_FAIL;
            else                      rcnt <= rnxt[LIM_W-1:0];
         end
      end
   end

   assign done = (st == CHK_DONE);
   assign fail = (st == CHK_FAIL);
endmodule

// File: rtl/link_stab_qual.sv
module link_stab_qual
   import lsq_pkg::*;
#(
   parameter int unsigned POLL_TICKS = 8,
   parameter int unsigned CNT_W      = PER_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_us,
   input  logic             link_raw,
   input  logic [2:0]       period_code,
   input  logic             start_go,
   input  logic [6:0]       valid_limit,
   input  logic [6:0]       retry_limit,
   output logic             link_up,
   output logic             startup_done,
   output logic             startup_fail
);
   generate
      if (POLL_TICKS < 1) begin : g_bad_poll
         $error("POLL_TICKS must be at least 1");
      end
      if (CNT_W < PER_CNT_W) begin : g_bad_cnt
         $error("CNT_W too narrow for the longest period");
      end
   endgenerate

   lsq_stab_timer #(.CNT_W(CNT_W)) i_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_us),
      .raw  (link_raw),
      .code (period_code),
      .up   (link_up)
   );

   lsq_startup_chk #(.POLL_TICKS(POLL_TICKS)) i_chk (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_us),
      .raw  (link_raw),
      .start(start_go),
      .vlim (valid_limit),
      .rlim (retry_limit),
      .done (startup_done),
      .fail (startup_fail)
   );
endmodule

// File: rtl/link_stab_qual_chk.sv
module link_stab_qual_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_us,
   input logic       link_raw,
   input logic [2:0] period_code,
   input logic       start_go,
   input logic [6:0] valid_limit,
   input logic       link_up,
   input logic       startup_done,
   input logic       startup_fail
);
   assert_low_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !link_raw |=> !link_up);

   assert_code0_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (period_code == 3'd0) |=> (link_up == $past(link_raw)));

   assert_no_tick_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_us && period_code != 3'd0 && !link_up) |=> !link_up);

   assert_zero_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_go && valid_limit == 7'd0) |=> startup_done);

   assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (startup_done && !start_go) |=> startup_done);

   assert_fail_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (startup_fail && !start_go) |=> startup_fail);
endmodule

bind link_stab_qual link_stab_qual_chk i_link_stab_qual_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_us     (tick_us),
   .link_raw    (link_raw),
   .period_code (period_code),
   .start_go    (start_go),
   .valid_limit (valid_limit),
   .link_up     (link_up),
   .startup_done(startup_done),
   .startup_fail(startup_fail)
);

// File: tb/test_link_stab_qual.sv
`timescale 1ns/1ps
module test_link_stab_qual;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_us = 1'b0;
   logic       link_raw = 1'b0;
   logic [2:0] period_code = 3'd2;
   logic       start_go = 1'b0;
   logic [6:0] valid_limit = 7'd3;
   logic [6:0] retry_limit = 7'd5;
   logic       link_up, startup_done, startup_fail;

   int n_checks = 0;
   int n_fails  = 0;
   int tick_div = 1;
   int tick_ph  = 0;

   always #10 clk = ~clk;

   always @(negedge clk) begin
      if (tick_div == 0) begin
         tick_us = 1'b0;
      end else begin
         tick_us = (tick_ph == 0);
         tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
      end
   end

   link_stab_qual i_link_stab_qual (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .link_raw(link_raw),
      .period_code(period_code), .start_go(start_go),
      .valid_limit(valid_limit), .retry_limit(retry_limit),
      .link_up(link_up), .startup_done(startup_done), .startup_fail(startup_fail)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clear_link();
      @(negedge clk) link_raw = 1'b0;
      clks(2);
   endtask

   // R2/R4: rise lands exactly on the L-th edge with ticks every cycle
   task automatic t_period(input logic [2:0] code, input int lim);
      clear_link();
      @(negedge clk);
      period_code = code;
      link_raw    = 1'b1;
      if (lim > 1) clks(lim - 1);
      check($sformatf("R2 code%0d early", code), link_up, 1'b0);
      clks(1);
      check($sformatf("R2 code%0d rise", code), link_up, 1'b1);
   endtask

   task automatic t_code0_follow();
      clear_link();
      @(negedge clk);
      period_code = 3'd0;
      link_raw    = 1'b1;
      #1 check("R4 before edge", link_up, 1'b0);
      clks(1);
      check("R4 high after one clock", link_up, 1'b1);
      @(negedge clk) link_raw = 1'b0;
      clks(1);
      check("R4 low after one clock", link_up, 1'b0);
   endtask

   task automatic t_drop_restart();
      clear_link();
      @(negedge clk);
      period_code = 3'd2;
      link_raw    = 1'b1;
      clks(1000);
      check("R3 up before drop", link_up, 1'b1);
      @(negedge clk) link_raw = 1'b0;
      clks(1);
      check("R3 drop next clock", link_up, 1'b0);
      @(negedge clk) link_raw = 1'b1;
      clks(600);
      @(negedge clk) link_raw = 1'b0;
      @(negedge clk) link_raw = 1'b1;
      clks(999);
      check("R3 restarted count not done early", link_up, 1'b0);
      clks(1);
      check("R3 restarted count completes", link_up, 1'b1);
   endtask

   task automatic t_tick_gating();
      clear_link();
      @(negedge clk);
      tick_div    = 0;
      period_code = 3'd2;
      link_raw    = 1'b1;
      clks(1500);
      check("R5 no ticks no qualify", link_up, 1'b0);
      clear_link();
      @(negedge clk);
      tick_div    = 4;
      tick_ph     = 0;
      period_code = 3'd1;
      link_raw    = 1'b1;
      clks(1990);
      check("R5 slow tick not yet", link_up, 1'b0);
      clks(20);
      check("R5 slow tick qualified", link_up, 1'b1);
      @(negedge clk) tick_div = 1;
   endtask

   task automatic pulse_start();
      @(negedge clk) start_go = 1'b1;
      @(posedge clk);
      @(negedge clk) start_go = 1'b0;
   endtask

   task automatic t_start_pass();
      @(negedge clk);
      link_raw = 1'b1; valid_limit = 7'd3; retry_limit = 7'd5;
      pulse_start();
      check("R9 start clears done", startup_done, 1'b0);
      clks(19);
      check("R6 not done before third poll", startup_done, 1'b0);
      clks(8);
      check("R6 done after third poll", startup_done, 1'b1);
      check("R6 no fail", startup_fail, 1'b0);
   endtask

   task automatic t_start_consecutive();
      @(negedge clk);
      link_raw = 1'b1; valid_limit = 7'd3; retry_limit = 7'd10;
      pulse_start();
      clks(17);
      @(negedge clk) link_raw = 1'b0;
      clks(8);
      @(negedge clk) link_raw = 1'b1;
      clks(19);
      check("R7 bad sample clears valid run", startup_done, 1'b0);
      clks(8);
      check("R7 done after three fresh goods", startup_done, 1'b1);
   endtask

   task automatic t_start_fail();
      @(negedge clk);
      link_raw = 1'b0; valid_limit = 7'd3; retry_limit = 7'd5;
      pulse_start();
      check("R9 start clears fail", startup_fail, 1'b0);
      clks(35);
      check("R7 not failed before fifth retry", startup_fail, 1'b0);
      clks(8);
      check("R7 fail after fifth retry", startup_fail, 1'b1);
      check("R7 no done", startup_done, 1'b0);
      @(negedge clk) link_raw = 1'b1;
      clks(60);
      check("R9 fail held", startup_fail, 1'b1);
      check("R9 done stays low", startup_done, 1'b0);
   endtask

   task automatic t_zero_limits();
      @(negedge clk);
      link_raw = 1'b0; valid_limit = 7'd0; retry_limit = 7'd4;
      pulse_start();
      check("R8 zero valid limit done", startup_done, 1'b1);
      @(negedge clk);
      valid_limit = 7'd2; retry_limit = 7'd0; link_raw = 1'b1;
      pulse_start();
      check("R8 zero retry limit fail", startup_fail, 1'b1);
      check("R9 done cleared by start", startup_done, 1'b0);
   endtask

   initial begin
      #(20 * 190000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      clks(3);
      check("R1 link_up reset", link_up, 1'b0);
      check("R1 done reset", startup_done, 1'b0);
      check("R1 fail reset", startup_fail, 1'b0);
      @(negedge clk) rst_n = 1'b1;
      link_raw = 1'b1;
      clks(2);
      check("R1 no early link_up", link_up, 1'b0);
      t_code0_follow();
      t_period(3'd0, 1);
      t_period(3'd1, 500);
      t_period(3'd2, 1000);
      t_period(3'd3, 64000);
      t_drop_restart();
      t_tick_gating();
      t_start_pass();
      t_start_consecutive();
      t_start_fail();
      t_zero_limits();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule